// File: doc/BRIEF.md
# Periodic Interrupt Divider Timer

A free-running binary up-counter that divides an oscillator-derived tick into a slow periodic event. Each enabled tick moves the count up by one. When the count wraps, a sticky event flag is raised. That flag is turned into two separate requests, an interrupt request and a wake-up (hold-release) request, each gated by its own enable bit.

The counter value is exported so that other blocks can tap its stages. Software-style commands are presented as single-cycle strobes. One strobe clears the event flag. Another zeroes only the top four counter stages, which realigns the coarse phase and leaves the fine phase alone. A length-select bit takes the event from the carry out of bit 12 instead of bit 13, which halves the period. At a 32768 Hz tick rate the two periods are 250 ms and 500 ms.

Top module: `pdiv_timer`

## Requirements
- R1: Each cycle in which `tick` and `run` are both 1 and `part_clr` is 0, `count` increases by one at the next edge and wraps from 16383 to 0.
- R2: With `short_sel` = 0, `evt_flag` becomes 1 at the edge where `count` wraps from 16383 to 0, which happens once every 16384 enabled ticks.
- R3: Once set, `evt_flag` stays 1 until a cycle with `flag_clr` = 1. It is then 0 after that edge, unless R10 applies.
- R4: `irq_req` is 1 exactly when `evt_flag` is 1 and `irq_en` is 1.
- R5: `wake_req` is 1 exactly when `evt_flag` is 1 and `wake_en` is 1.
- R6: In a cycle with `part_clr` = 1, `count[13:10]` becomes 0 at the next edge. `count[9:0]` keeps its value, or increases by one modulo 1024 if the tick is enabled, with no carry into bit 10. No event is raised in that cycle.
- R7: When `tick` = 0 or `run` = 0, and `part_clr` = 0, `count` holds its value.
- R8: Under reset (`rst_n` = 0), `count` and `evt_flag` are 0.
- R9: With `short_sel` = 1, `evt_flag` becomes 1 at the edge where `count[12:0]` wraps from 8191 to 0. That happens every 8192 enabled ticks, and bit 13 keeps counting.
- R10: If `flag_clr` = 1 in the same cycle as a new event, `evt_flag` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-enable strobe from the oscillator divider |
| run | input | 1 | Oscillator source enabled |
| short_sel | input | 1 | 1: event on 13-bit wrap, 0: event on 14-bit wrap |
| irq_en | input | 1 | Interrupt request enable |
| wake_en | input | 1 | Hold-release request enable |
| flag_clr | input | 1 | Clears the event flag |
| part_clr | input | 1 | Zeroes the top four counter stages |
| evt_flag | output | 1 | Sticky overflow event flag |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Hold-release request |
| count | output | 14 | Counter value for stage taps |

## Verification
The counter is driven with ticks on every cycle, with ticks on alternate cycles, and with ticks present while `run` is low. These patterns separate the tick gate from the run gate. Full 14-bit runs and 13-bit runs place the event at two different wrap points, so a wrong tap bit shows up as an event at the wrong count. Partial clears are applied at a mid-range value, at the all-ones value and together with an enabled tick, which shows that the low stages survive and that no carry leaks into the cleared bits. A flag clear is also timed onto an overflow cycle, which separates set-priority from clear-priority.

// File: rtl/pdiv_timer.sv
module pdiv_timer #(
  parameter int CNT_W      = 14,
  parameter int CLR_STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             short_sel,
  input  logic             irq_en,
  input  logic             wake_en,
  input  logic             flag_clr,
  input  logic             part_clr,
  output logic             evt_flag,
  output logic             irq_req,
  output logic             wake_req,
  output logic [CNT_W-1:0] count
);
  localparam int LOW_W = CNT_W - CLR_STAGES;

  logic             adv;
  logic [CNT_W:0]   sum;
  logic [LOW_W-1:0] low_next;
  logic             wrap_long, wrap_short, ovf;
  logic [CNT_W-1:0] cnt_next;

  assign adv        = tick & run;
  assign sum        = {1'b0, count} + (CNT_W+1)'(adv);
  assign low_next   = count[LOW_W-1:0] + LOW_W'(adv);
  assign wrap_long  = sum[CNT_W];
  assign wrap_short = adv & (&count[CNT_W-2:0]);
  assign ovf        = ~part_clr & (short_sel ? wrap_short : wrap_long);
  assign cnt_next   = part_clr ? {{CLR_STAGES{1'b0}}, low_next} : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      evt_flag <= 1'b0;
    end else begin
      count <= cnt_next;
      if (ovf)           evt_flag <= 1'b1;
      else if (flag_clr) evt_flag <= 1'b0;
    end
  end

  assign irq_req  = evt_flag & irq_en;
  assign wake_req = evt_flag & wake_en;
endmodule

module pdiv_timer_chk #(
  parameter int CNT_W      = 14,
  parameter int CLR_STAGES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             short_sel,
  input logic             irq_en,
  input logic             wake_en,
  input logic             flag_clr,
  input logic             part_clr,
  input logic             evt_flag,
  input logic             irq_req,
  input logic             wake_req,
  input logic [CNT_W-1:0] count
);
  localparam int LOW_W = CNT_W - CLR_STAGES;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !part_clr) |=> count == CNT_W'($past(count) + 1'b1));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run) && !part_clr) |=> $stable(count));

  p_part_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    part_clr |=> (count[CNT_W-1:LOW_W] == '0) &&
                 (count[LOW_W-1:0] == LOW_W'($past(count[LOW_W-1:0]) + LOW_W'($past(tick && run)))));

  p_no_evt_on_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (part_clr && !evt_flag) |=> !evt_flag);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !flag_clr) |=> evt_flag);

  p_evt_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_flag && !short_sel) ##1 evt_flag |-> count == '0);

  p_evt_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_flag && short_sel) ##1 evt_flag |-> count[CNT_W-2:0] == '0);

  p_req_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || wake_req) |-> evt_flag);
endmodule

bind pdiv_timer pdiv_timer_chk #(.CNT_W(CNT_W), .CLR_STAGES(CLR_STAGES)) u_chk (.*);

// File: tb/pdiv_timer_bench.sv
module pdiv_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, short_sel = 1'b0, irq_en = 1'b0, wake_en = 1'b0;
  logic flag_clr = 1'b0, part_clr = 1'b0;
  logic evt_flag, irq_req, wake_req;
  logic [13:0] count;

  always #5 clk = ~clk;

  pdiv_timer u_pdiv_timer (.*);

  typedef struct packed {
    logic [13:0] cnt;
    logic        flag;
    logic        irq;
    logic        wake;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic [13:0] m_cnt = '0;
  logic        m_flag = 1'b0;
  bit          done = 0;

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic t, input logic r, input logic sh, input logic ie,
                      input logic we, input logic fc, input logic pc);
    logic adv, ovf;
    exp_t e;
    @(negedge clk);
    tick = t; run = r; short_sel = sh; irq_en = ie; wake_en = we;
    flag_clr = fc; part_clr = pc;
    adv = t & r;
    ovf = adv && !pc && (sh ? (m_cnt[12:0] == 13'h1FFF) : (m_cnt == 14'h3FFF));
    if (pc) m_cnt = {4'b0, 10'(m_cnt[9:0] + 10'(adv))};
    else    m_cnt = m_cnt + 14'(adv);
    if (ovf)     m_flag = 1'b1;
    else if (fc) m_flag = 1'b0;
    e.cnt = m_cnt; e.flag = m_flag; e.irq = m_flag & ie; e.wake = m_flag & we;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R1/R6/R7 count", count, e.cnt);
      chk("R2/R3/R9/R10 evt_flag", 14'(evt_flag), 14'(e.flag));
      chk("R4 irq_req", 14'(irq_req), 14'(e.irq));
      chk("R5 wake_req", 14'(wake_req), 14'(e.wake));
    end
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset count", count, 14'h0);
    chk("R8 reset flag", 14'(evt_flag), 14'h0);
    rst_n = 1'b1;
    // R1: plain counting
    repeat (20) step(1, 1, 0, 0, 0, 0, 0);
    // R7: ticks without run, run without ticks, alternate ticks
    repeat (10) step(1, 0, 0, 0, 0, 0, 0);
    repeat (10) step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(1'(i % 2), 1, 0, 0, 0, 0, 0);
    // R6: partial clear mid-range, with and without tick
    while (m_cnt != 14'h1234) step(1, 1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 1);
    while (m_cnt != 14'h07FE) step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 1);
    // R2 with requests gated off (R4, R5)
    while (m_cnt != 14'h3FFF) step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    // R3 sticky, then request gating R4 and R5
    repeat (5) step(0, 1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 1, 0, 0);
    step(1, 1, 0, 1, 1, 0, 0);
    step(1, 1, 0, 1, 1, 1, 0);
    repeat (3) step(1, 1, 0, 1, 1, 0, 0);
    // R6: partial clear at all-ones suppresses the event
    while (m_cnt != 14'h3FFF) step(1, 1, 0, 1, 0, 0, 0);
    step(1, 1, 0, 1, 0, 0, 1);
    repeat (3) step(1, 1, 0, 1, 0, 0, 0);
    // R9: short mode, event on 13-bit wrap, bit 13 continues
    while (m_cnt[12:0] != 13'h1FFF) step(1, 1, 1, 0, 1, 0, 0);
    step(1, 1, 1, 0, 1, 0, 0);
    step(1, 1, 1, 0, 1, 1, 0);
    while (m_cnt[12:0] != 13'h1FFF) step(1, 1, 1, 0, 1, 0, 0);
    step(1, 1, 1, 0, 1, 0, 0);
    // R10: clear on the overflow cycle, set wins
    step(1, 1, 1, 1, 0, 1, 0);
    while (m_cnt[12:0] != 13'h1FFF) step(1, 1, 1, 1, 0, 0, 0);
    step(1, 1, 1, 1, 0, 1, 0);
    repeat (2) step(0, 1, 1, 1, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    report();
  end
endmodule